// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block tracks which cache lines are currently reserved by a load-linked operation, and which requester holds each reservation. It watches the stream of completed write-class operations. Each operation arrives with a line address, an operation kind and a requester identifier. From this stream the block decides whether each store-conditional succeeds. Reservations live in a small fully associative table. A load-linked to a line that already holds a reservation retags that entry. A load-linked to a new line takes a free entry, or replaces the entry allocated longest ago when every entry is in use.

Any store-conditional drops the reservation on its line, whether it succeeds or not. An ordinary write from the reservation's owner also drops it. The block also emits one-cycle hold and release pulses, tagged with the line, when a locked read-modify-write pair completes, so that the request queue for that line can be paused. A separate invalidate input removes a reservation when coherence takes the line away. A bypass input turns all reservation handling off.

Top module: `llsc_monitor`

## Requirements
- R1: After reset the table holds no reservation and `sc_valid`, `sc_pass`, `hold_valid` and `release_valid` are low; a reservation made before a reset does not survive it.
- R2: A completion of kind 1 (load-linked) reserves its line for its requester; a later completion of kind 2 (store-conditional) on that line from the same requester reports success (`sc_pass`=1).
- R3: A store-conditional on a line that holds no reservation, or that is reserved by a different requester, reports failure (`sc_pass`=0).
- R4: Every store-conditional removes the reservation on its line, pass or fail, whichever requester owns it.
- R5: Kinds 0 (store), 3 (locked read), 4 (locked write), 5 (read-modify-write), 6 (atomic) and 7 (flush) are ordinary writes: they remove a reservation on their line only when it belongs to the same requester, and leave another requester's reservation in place.
- R6: A load-linked to a line that is already reserved retags the existing entry to the new requester; a line never occupies two entries.
- R7: The table holds `N_ENT` reservations; a load-linked to a new line while all are in use evicts the entry allocated longest ago. Removals keep the allocation order of the survivors.
- R8: `inv_valid` with `inv_line` removes any reservation on that line; a store-conditional to that line in the same cycle sees it already removed and fails.
- R9: While `bypass_en` is high, every store-conditional reports success and no completion changes the table.
- R10: A kind-3 completion raises `hold_valid` with `hold_line` for one cycle on the next clock; a kind-4 completion does the same on `release_valid` / `release_line`; this is independent of `bypass_en`.
- R11: `sc_valid` rises exactly one cycle after a valid store-conditional completion and at no other time; `sc_pass` is low whenever `sc_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bypass_en | input | 1 | Disable all reservation handling |
| cmp_valid | input | 1 | A completed operation is presented |
| cmp_kind | input | 3 | Operation kind code (see R2, R5) |
| cmp_line | input | LINE_W | Line address of the completion |
| cmp_req | input | REQ_W | Requester identifier of the completion |
| inv_valid | input | 1 | Invalidate strobe |
| inv_line | input | LINE_W | Line address to invalidate |
| sc_valid | output | 1 | Store-conditional result strobe |
| sc_pass | output | 1 | Store-conditional result, 1 on success |
| hold_valid | output | 1 | Pause the request queue of `hold_line` |
| hold_line | output | LINE_W | Line to pause |
| release_valid | output | 1 | Resume the request queue of `release_line` |
| release_line | output | LINE_W | Line to resume |

## Verification
The hardest state to reach is replacement when the table is full and its allocation order has already been disturbed by removals. To decide the victim correctly, the age ranks of the surviving entries must have been closed up correctly. The stimulus first fills the table and forces one eviction. It then removes the youngest and the oldest entries with store-conditionals, refills the table, and forces a second eviction. The second victim is the correct one only if the rank compaction worked. Same-cycle races are reached by presenting an invalidate together with a store-conditional to the same line.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
  typedef enum logic [2:0] {
    OP_STORE = 3'd0,
    OP_LL    = 3'd1,
    OP_SC    = 3'd2,
    OP_LKRD  = 3'd3,
    OP_LKWR  = 3'd4,
    OP_RMW   = 3'd5,
    OP_ATOM  = 3'd6,
    OP_FLUSH = 3'd7
  } op_kind_e;
endpackage

// File: rtl/rsv_cam.sv
module rsv_cam #(
  parameter int N      = 4,
  parameter int LINE_W = 8,
  parameter int REQ_W  = 2
) (
  input  logic [N-1:0]      valid_q,
  input  logic [LINE_W-1:0] line_q  [N],
  input  logic [REQ_W-1:0]  owner_q [N],
  input  logic [LINE_W-1:0] cmp_line,
  input  logic [REQ_W-1:0]  cmp_req,
  input  logic              inv_valid,
  input  logic [LINE_W-1:0] inv_line,
  output logic [N-1:0]      kill,
  output logic [N-1:0]      hit,
  output logic [N-1:0]      mine
);
  // Invalidation is applied ahead of the lookup, so a completion in the
  // same cycle sees the line already gone.
  for (genvar i = 0; i < N; i++) begin : g_ent
    assign kill[i] = inv_valid & valid_q[i] & (line_q[i] == inv_line);
    assign hit[i]  = valid_q[i] & ~kill[i] & (line_q[i] == cmp_line);
    assign mine[i] = (owner_q[i] == cmp_req);
  end
endmodule

// File: rtl/rsv_age.sv
module rsv_age #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] valid_q,
  input  logic [N-1:0] freed,
  input  logic [N-1:0] alloc,
  input  logic         full,
  output logic [N-1:0] victim
);
  localparam int RW = (N > 1) ? $clog2(N) : 1;
  localparam logic [RW-1:0] OLDEST = RW'(N - 1);

  logic [RW-1:0] rank_q [N];
  logic [RW-1:0] rank_d [N];
  logic          any_alloc;

  assign any_alloc = |alloc;

  // Rank 0 is the youngest allocation. A freed entry closes the gap above it.
  always_comb begin
    for (int i = 0; i < N; i++) begin
      logic [RW:0] below;
      logic [RW:0] tmp;
      below = '0;
      for (int j = 0; j < N; j++) begin
        if (freed[j] && (rank_q[j] < rank_q[i])) below = below + 1'b1;
      end
      tmp = {1'b0, rank_q[i]} - below + {{RW{1'b0}}, any_alloc};
      if (alloc[i])                      rank_d[i] = '0;
      else if (valid_q[i] && !freed[i])  rank_d[i] = tmp[RW-1:0];
      else                               rank_d[i] = '0;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_rank
    always_ff @(posedge clk) begin
      if (rst) rank_q[i] <= '0;
      else     rank_q[i] <= rank_d[i];
    end
    assign victim[i] = full & valid_q[i] & (rank_q[i] == OLDEST);

    // Live ranks stay packed in 0..count-1, which makes the oldest unique.
    assert_rank_packed_R7: assert property (@(posedge clk) disable iff (rst)
      valid_q[i] |-> (int'(rank_q[i]) < $countones(valid_q)));
  end

  assert_one_victim_R7: assert property (@(posedge clk) disable iff (rst)
    full |-> $onehot(victim));
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor #(
  parameter int N_ENT  = 4,
  parameter int LINE_W = 8,
  parameter int REQ_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bypass_en,
  input  logic              cmp_valid,
  input  logic [2:0]        cmp_kind,
  input  logic [LINE_W-1:0] cmp_line,
  input  logic [REQ_W-1:0]  cmp_req,
  input  logic              inv_valid,
  input  logic [LINE_W-1:0] inv_line,
  output logic              sc_valid,
  output logic              sc_pass,
  output logic              hold_valid,
  output logic [LINE_W-1:0] hold_line,
  output logic              release_valid,
  output logic [LINE_W-1:0] release_line
);
  import llsc_pkg::*;

  logic [N_ENT-1:0]  valid_q;
  logic [LINE_W-1:0] line_q  [N_ENT];
  logic [REQ_W-1:0]  owner_q [N_ENT];

  logic [N_ENT-1:0]  kill, hit, mine;
  logic [N_ENT-1:0]  eff_valid, clr, retag, alloc, first_free, victim, freed;
  logic              is_ll, is_sc, is_plain, act, sc_act, hit_mine, any_hit, full;
  logic              need_alloc, found;
  op_kind_e          kind;

  assign kind     = op_kind_e'(cmp_kind);
  assign is_ll    = (kind == OP_LL);
  assign is_sc    = (kind == OP_SC);
  assign is_plain = !is_ll && !is_sc;
  assign act      = cmp_valid & ~bypass_en;
  assign sc_act   = act & is_sc;

  rsv_cam #(.N(N_ENT), .LINE_W(LINE_W), .REQ_W(REQ_W)) u_cam (
    .valid_q  (valid_q),
    .line_q   (line_q),
    .owner_q  (owner_q),
    .cmp_line (cmp_line),
    .cmp_req  (cmp_req),
    .inv_valid(inv_valid),
    .inv_line (inv_line),
    .kill     (kill),
    .hit      (hit),
    .mine     (mine)
  );

  assign eff_valid = valid_q & ~kill;
  assign any_hit   = |hit;
  assign hit_mine  = |(hit & mine);
  assign full      = &eff_valid;

  always_comb begin
    first_free = '0;
    found      = 1'b0;
    for (int i = 0; i < N_ENT; i++) begin
      if (!eff_valid[i] && !found) begin
        first_free[i] = 1'b1;
        found         = 1'b1;
      end
    end
  end

  rsv_age #(.N(N_ENT)) u_age (
    .clk    (clk),
    .rst    (rst),
    .valid_q(valid_q),
    .freed  (freed),
    .alloc  (alloc),
    .full   (full),
    .victim (victim)
  );

  assign need_alloc = act & is_ll & ~any_hit;
  assign alloc      = need_alloc ? (full ? victim : first_free) : '0;
  assign retag      = (act & is_ll) ? hit : '0;
  assign clr        = sc_act ? hit : ((act & is_plain) ? (hit & mine) : '0);
  assign freed      = valid_q & (kill | clr | (alloc & eff_valid));

  for (genvar i = 0; i < N_ENT; i++) begin : g_tab
    always_ff @(posedge clk) begin
      if (rst) valid_q[i] <= 1'b0;
      else     valid_q[i] <= (eff_valid[i] & ~clr[i]) | alloc[i];
    end
    always_ff @(posedge clk) begin
      if (alloc[i]) line_q[i] <= cmp_line;
      if (alloc[i] || retag[i]) owner_q[i] <= cmp_req;
    end

    // An SC leaves no reservation behind on its line.
    assert_sc_drops_line_R4: assert property (@(posedge clk) disable iff (rst)
      sc_act |=> !(valid_q[i] && (line_q[i] == $past(cmp_line))));

    for (genvar j = i + 1; j < N_ENT; j++) begin : g_pair
      assert_line_unique_R6: assert property (@(posedge clk) disable iff (rst)
        !(valid_q[i] && valid_q[j] && (line_q[i] == line_q[j])));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sc_valid      <= 1'b0;
      sc_pass       <= 1'b0;
      hold_valid    <= 1'b0;
      release_valid <= 1'b0;
      hold_line     <= '0;
      release_line  <= '0;
    end else begin
      sc_valid      <= cmp_valid & is_sc;
      sc_pass       <= cmp_valid & is_sc & (bypass_en | hit_mine);
      hold_valid    <= cmp_valid & (kind == OP_LKRD);
      release_valid <= cmp_valid & (kind == OP_LKWR);
      if (cmp_valid && kind == OP_LKRD) hold_line    <= cmp_line;
      if (cmp_valid && kind == OP_LKWR) release_line <= cmp_line;
    end
  end

  assert_sc_timing_R11: assert property (@(posedge clk) disable iff (rst)
    (cmp_valid && is_sc) |=> sc_valid);

  assert_pass_gated_R11: assert property (@(posedge clk) disable iff (rst)
    !sc_valid |-> !sc_pass);

  assert_bypass_pass_R9: assert property (@(posedge clk) disable iff (rst)
    (cmp_valid && is_sc && bypass_en) |=> sc_pass);

  assert_bypass_frozen_R9: assert property (@(posedge clk) disable iff (rst)
    (bypass_en && !inv_valid) |=> $stable(valid_q));

  assert_hold_excl_R10: assert property (@(posedge clk) disable iff (rst)
    !(hold_valid && release_valid));
endmodule

// File: tb/llsc_monitor_bench.sv
module llsc_monitor_bench;
  localparam int N_ENT  = 4;
  localparam int LINE_W = 8;
  localparam int REQ_W  = 2;

  typedef struct packed {
    logic              v;
    logic [2:0]        k;
    logic [LINE_W-1:0] ln;
    logic [REQ_W-1:0]  rq;
    logic              iv;
    logic [LINE_W-1:0] il;
    logic              by;
    logic              scv;
    logic              ps;
    logic              ho;
    logic              re;
    logic [3:0]        tag;
  } vec_t;

  localparam int NV = 44;
  // Fields: valid, kind, line, req, inv, inv line, bypass,
  //         exp sc_valid, exp sc_pass, exp hold, exp release, requirement.
  localparam vec_t VEC [NV] = '{
    '{1,1,'h10,1,0,0,0, 0,0,0,0, 2},  // R2 LL
    '{1,2,'h10,1,0,0,0, 1,1,0,0, 2},  // R2 SC pass
    '{1,2,'h10,1,0,0,0, 1,0,0,0, 4},  // R4 lock gone
    '{1,1,'h10,1,0,0,0, 0,0,0,0, 3},
    '{1,2,'h10,2,0,0,0, 1,0,0,0, 3},  // R3 other requester
    '{1,2,'h10,1,0,0,0, 1,0,0,0, 4},  // R4 failed SC cleared it
    '{1,2,'h20,0,0,0,0, 1,0,0,0, 3},  // R3 never reserved
    '{1,1,'h10,1,0,0,0, 0,0,0,0, 5},
    '{1,0,'h10,2,0,0,0, 0,0,0,0, 5},  // R5 foreign store
    '{1,2,'h10,1,0,0,0, 1,1,0,0, 5},  // R5 lock kept
    '{1,1,'h10,1,0,0,0, 0,0,0,0, 5},
    '{1,5,'h10,1,0,0,0, 0,0,0,0, 5},  // R5 own RMW
    '{1,2,'h10,1,0,0,0, 1,0,0,0, 5},  // R5 lock dropped
    '{1,1,'h10,1,0,0,0, 0,0,0,0, 6},
    '{1,1,'h10,2,0,0,0, 0,0,0,0, 6},  // R6 retag
    '{1,2,'h10,2,0,0,0, 1,1,0,0, 6},
    '{1,1,'h10,0,0,0,0, 0,0,0,0, 8},
    '{0,0,'h00,0,1,'h10,0, 0,0,0,0, 8},  // R8 invalidate
    '{1,2,'h10,0,0,0,0, 1,0,0,0, 8},
    '{1,1,'h10,0,0,0,0, 0,0,0,0, 8},
    '{1,2,'h10,0,1,'h10,0, 1,0,0,0, 8},  // R8 same cycle
    '{1,2,'h30,3,0,0,1, 1,1,0,0, 9},  // R9 bypass pass
    '{1,1,'h31,0,0,0,1, 0,0,0,0, 9},
    '{1,2,'h31,0,0,0,0, 1,0,0,0, 9},  // R9 LL in bypass ignored
    '{1,1,'h31,0,0,0,0, 0,0,0,0, 9},
    '{1,0,'h31,0,0,0,1, 0,0,0,0, 9},
    '{1,2,'h31,0,0,0,0, 1,1,0,0, 9},  // R9 store in bypass ignored
    '{1,3,'h50,2,0,0,0, 0,0,1,0, 10}, // R10 hold
    '{1,4,'h50,2,0,0,1, 0,0,0,1, 10}, // R10 release in bypass
    '{0,2,'h50,0,0,0,0, 0,0,0,0, 11}, // R11 not valid
    '{1,7,'h60,1,0,0,0, 0,0,0,0, 11},
    '{1,1,'h41,0,0,0,0, 0,0,0,0, 7},
    '{1,1,'h42,0,0,0,0, 0,0,0,0, 7},
    '{1,1,'h43,0,0,0,0, 0,0,0,0, 7},
    '{1,1,'h44,0,0,0,0, 0,0,0,0, 7},
    '{1,1,'h45,0,0,0,0, 0,0,0,0, 7},  // R7 evicts 41
    '{1,2,'h41,0,0,0,0, 1,0,0,0, 7},
    '{1,2,'h42,0,0,0,0, 1,1,0,0, 7},
    '{1,2,'h45,0,0,0,0, 1,1,0,0, 7},
    '{1,1,'h46,0,0,0,0, 0,0,0,0, 7},
    '{1,1,'h47,0,0,0,0, 0,0,0,0, 7},
    '{1,1,'h48,0,0,0,0, 0,0,0,0, 7},  // R7 evicts 43
    '{1,2,'h43,0,0,0,0, 1,0,0,0, 7},
    '{1,2,'h44,0,0,0,0, 1,1,0,0, 7}
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              bypass_en = 1'b0;
  logic              cmp_valid = 1'b0;
  logic [2:0]        cmp_kind = '0;
  logic [LINE_W-1:0] cmp_line = '0;
  logic [REQ_W-1:0]  cmp_req = '0;
  logic              inv_valid = 1'b0;
  logic [LINE_W-1:0] inv_line = '0;
  logic              sc_valid, sc_pass, hold_valid, release_valid;
  logic [LINE_W-1:0] hold_line, release_line;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  llsc_monitor #(.N_ENT(N_ENT), .LINE_W(LINE_W), .REQ_W(REQ_W)) u_llsc_monitor (
    .clk(clk), .rst(rst), .bypass_en(bypass_en),
    .cmp_valid(cmp_valid), .cmp_kind(cmp_kind), .cmp_line(cmp_line),
    .cmp_req(cmp_req), .inv_valid(inv_valid), .inv_line(inv_line),
    .sc_valid(sc_valid), .sc_pass(sc_pass),
    .hold_valid(hold_valid), .hold_line(hold_line),
    .release_valid(release_valid), .release_line(release_line)
  );

  task automatic drive(input vec_t t);
    cmp_valid = t.v;  cmp_kind = t.k;  cmp_line = t.ln;  cmp_req = t.rq;
    inv_valid = t.iv; inv_line = t.il; bypass_en = t.by;
  endtask

  task automatic check(input vec_t t, input int idx);
    logic [3:0] got, exp;
    got = {sc_valid, sc_pass, hold_valid, release_valid};
    exp = {t.scv, t.ps, t.ho, t.re};
    n_chk++;
    if (got !== exp ||
        (t.ho && hold_line !== t.ln) || (t.re && release_line !== t.ln)) begin
      n_bad++;
      $display("FAIL R%0d vec %0d: got v/p/h/r=%b lines %h/%h, exp %b line %h",
               t.tag, idx, got, hold_line, release_line, exp, t.ln);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    vec_t idle;
    vec_t t;
    idle = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: outputs quiet straight after reset
    n_chk++;
    if ({sc_valid, sc_pass, hold_valid, release_valid} !== 4'b0) begin
      n_bad++;
      $display("FAIL R1 reset outputs: got %b exp 0000",
               {sc_valid, sc_pass, hold_valid, release_valid});
    end

    for (int k = 0; k < NV; k++) begin
      drive(VEC[k]);
      @(negedge clk);
      check(VEC[k], k);
    end

    // R1: a reservation does not survive a reset
    t = '{1,1,'h70,0,0,0,0, 0,0,0,0, 1};
    drive(t);
    @(negedge clk);
    drive(idle);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    t = '{1,2,'h70,0,0,0,0, 1,0,0,0, 1};
    drive(t);
    @(negedge clk);
    check(t, NV);
    drive(idle);
    @(negedge clk);
    check(idle, NV + 1);  // R11: strobe lasts one cycle

    done = 1'b1;
    finish_run();
  end
endmodule